// File: doc/BRIEF.md
# Post-Reset Self-Configuration Sequencer

This block runs the start-up routine of a network controller whenever it comes out of reset. A reset can come from the external reset pin or from an internal restart when the controller wakes from a low-power state. After either one, the block first holds a calibration phase. That phase lasts a programmable number of clock cycles and also waits for the analog circuit to report completion. The block then asks the configuration EEPROM reader for its contents. It loads the returned word when the reader marks it valid, and it loads a built-in default word when the reader marks it invalid.

Two status flags tell host software what state the block is in. The busy flag stays high for the whole routine. The ready flag rises at the same edge on which busy falls. While busy is high, host writes to the configuration word are refused and reported on an error output. Once the block is ready, host writes take effect.

Top module: `selfcfg_seq`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `si_busy`=1, `init_done`=0, `ee_rd`=0, `host_err`=0, and `cfg_q` equals the parameter `DEFAULT_CFG`.
- R2: `cal_req` is 1 exactly while the calibration phase runs. The phase is left on the first edge at which at least `CAL_CYCLES` edges have passed since it began and `cal_done` has been high in at least one cycle of the phase, including the current one.
- R3: After calibration, `ee_rd` is 1 from the next cycle on. It stays 1 until the edge at which `ee_done` is sampled high, and it is 0 at all other times.
- R4: When `ee_done`=1 and `ee_valid`=1 while `ee_rd`=1, `cfg_q` takes the value of `ee_data` on that edge.
- R5: When `ee_done`=1 and `ee_valid`=0 while `ee_rd`=1, `cfg_q` takes `DEFAULT_CFG`, and the routine still completes.
- R6: On the edge that finishes the EEPROM read, `si_busy` falls and `init_done` rises together. The two flags are never 1 at the same time, and `init_done` stays 1 until the next reset.
- R7: A host write (`host_wr`=1) sampled while `si_busy`=1, or in the same cycle as `lp_exit`, sets `host_err` to 1 for the following cycle and leaves `cfg_q` unchanged.
- R8: A host write sampled while `si_busy`=0 and `lp_exit`=0 loads `host_wdata` into `cfg_q` on that edge and leaves `host_err` at 0.
- R9: An `lp_exit` pulse in any state, including in the middle of the routine, gives `si_busy`=1 and `init_done`=0 on the next cycle and restarts calibration with a fresh cycle count and a fresh `cal_done` record. It takes priority over `ee_done` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| lp_exit | input | 1 | Internal restart pulse on leaving a low-power state |
| cal_req | output | 1 | Calibration phase active |
| cal_done | input | 1 | Analog calibration reports completion |
| ee_rd | output | 1 | Request to the EEPROM reader, held until done |
| ee_done | input | 1 | EEPROM reader finished |
| ee_valid | input | 1 | EEPROM contents valid (qualifies ee_done) |
| ee_data | input | CFG_W | Configuration word read from the EEPROM |
| host_wr | input | 1 | Host write strobe for the configuration word |
| host_wdata | input | CFG_W | Host write data |
| host_err | output | 1 | Host write refused in the previous cycle |
| cfg_q | output | CFG_W | Current configuration word |
| si_busy | output | 1 | Self-initialization in progress |
| init_done | output | 1 | Self-initialization complete |

## Verification
A wrong phase shows up within one cycle as a wrong level on `cal_req` or `ee_rd`. A miscounted calibration timer moves the rising edge of `ee_rd` by at least one cycle. A lost restart or a missed `cal_done` record shifts the busy/ready flags by a whole calibration window. A host write that gets through during the routine changes `cfg_q` on the next cycle, and the wrong fallback for an invalid EEPROM shows on `cfg_q` as soon as ready rises. The bench runs a cycle model next to the design and compares every output at every cycle.

// File: rtl/selfcfg_pkg.sv
package selfcfg_pkg;

  typedef enum logic [1:0] {
    PH_CAL    = 2'd0,
    PH_EEPROM = 2'd1,
    PH_READY  = 2'd2
  } phase_e;

  // Saturating step of the calibration counter
  function automatic logic [31:0] cal_step(input logic [31:0] cur, input logic [31:0] last);
    return (cur >= last) ? last : cur + 32'd1;
  endfunction

  // Configuration word picked at EEPROM completion
  function automatic logic [31:0] ee_pick(input logic valid, input logic [31:0] data,
                                          input logic [31:0] dflt);
    return valid ? data : dflt;
  endfunction

endpackage

// File: rtl/selfcfg_timer.sv
module selfcfg_timer
  import selfcfg_pkg::*;
#(
  parameter int CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (run)  cnt <= CW'(cal_step(32'(cnt), 32'(LAST)));
  end

  assign expired = (cnt == LAST);

  // Once expired, the timer stays expired until it is cleared
  assert_timer_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr) |=> expired);

  // A cleared timer is not expired on the next cycle
  assert_timer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (CYCLES == 1) || !expired);

endmodule

// File: rtl/selfcfg_store.sv
module selfcfg_store
  import selfcfg_pkg::*;
#(
  parameter int          CFG_W       = 16,
  parameter logic [CFG_W-1:0] DEFAULT_CFG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ee_load,
  input  logic             ee_valid,
  input  logic [CFG_W-1:0] ee_data,
  input  logic             host_ok,
  input  logic [CFG_W-1:0] host_wdata,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] ee_word;
  assign ee_word = CFG_W'(ee_pick(ee_valid, 32'(ee_data), 32'(DEFAULT_CFG)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= DEFAULT_CFG;
    else if (ee_load)  cfg_q <= ee_word;
    else if (host_ok)  cfg_q <= host_wdata;
  end

  // The EEPROM load and the host write never compete
  assert_single_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ee_load && host_ok));

  // The configuration changes only through one of the two load paths
  assert_cfg_paths_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_load && !host_ok) |=> $stable(cfg_q));

endmodule

// File: rtl/selfcfg_seq.sv
module selfcfg_seq
  import selfcfg_pkg::*;
#(
  parameter int               CAL_CYCLES  = 200000,
  parameter int               CFG_W       = 16,
  parameter logic [CFG_W-1:0] DEFAULT_CFG = 16'h0A5C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_exit,
  output logic             cal_req,
  input  logic             cal_done,
  output logic             ee_rd,
  input  logic             ee_done,
  input  logic             ee_valid,
  input  logic [CFG_W-1:0] ee_data,
  input  logic             host_wr,
  input  logic [CFG_W-1:0] host_wdata,
  output logic             host_err,
  output logic [CFG_W-1:0] cfg_q,
  output logic             si_busy,
  output logic             init_done
);
  phase_e phase;
  logic   cal_seen;
  logic   timer_expired;

  // Named internal events
  logic restart_w, cal_pass_w, ee_load_w, host_ok_w, timer_clr_w, timer_run_w;

  assign restart_w   = lp_exit;
  assign cal_pass_w  = (phase == PH_CAL) && timer_expired && (cal_seen || cal_done) && !restart_w;
  assign ee_load_w   = (phase == PH_EEPROM) && ee_done && !restart_w;
  assign host_ok_w   = host_wr && !si_busy && !restart_w;
  assign timer_run_w = (phase == PH_CAL);
  assign timer_clr_w = restart_w || (phase != PH_CAL);

  selfcfg_timer #(.CYCLES(CAL_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (timer_clr_w),
    .run     (timer_run_w),
    .expired (timer_expired)
  );

  selfcfg_store #(.CFG_W(CFG_W), .DEFAULT_CFG(DEFAULT_CFG)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ee_load    (ee_load_w),
    .ee_valid   (ee_valid),
    .ee_data    (ee_data),
    .host_ok    (host_ok_w),
    .host_wdata (host_wdata),
    .cfg_q      (cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CAL;
      cal_seen  <= 1'b0;
      si_busy   <= 1'b1;
      init_done <= 1'b0;
      host_err  <= 1'b0;
    end else begin
      host_err <= host_wr && (si_busy || restart_w);
      if (restart_w) begin
        phase     <= PH_CAL;
        cal_seen  <= 1'b0;
        si_busy   <= 1'b1;
        init_done <= 1'b0;
      end else begin
        if (phase == PH_CAL) cal_seen <= cal_seen || cal_done;
        if (cal_pass_w) begin
          phase    <= PH_EEPROM;
          cal_seen <= 1'b0;
        end else if (ee_load_w) begin
          phase     <= PH_READY;
          si_busy   <= 1'b0;
          init_done <= 1'b1;
        end
      end
    end
  end

  assign cal_req = (phase == PH_CAL);
  assign ee_rd   = (phase == PH_EEPROM);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(si_busy && init_done));

  assert_ready_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !lp_exit) |=> init_done);

  assert_restart_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit |=> (si_busy && !init_done && cal_req));

  assert_eeprom_after_cal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_rd) |-> $past(timer_expired));

  assert_busy_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && si_busy) |=> host_err);

  assert_busy_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (si_busy && !ee_load_w) |=> $stable(cfg_q));

  assert_load_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_load_w |=> (init_done && !si_busy && !ee_rd));

endmodule

// File: tb/tb_selfcfg_seq.sv
module tb_selfcfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCAL = 8;
  localparam int W = 16;
  localparam logic [W-1:0] DFLT = 16'h0A5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_exit = 0, cal_done = 0, ee_done = 0, ee_valid = 0, host_wr = 0;
  logic [W-1:0] ee_data = '0, host_wdata = '0;
  logic cal_req, ee_rd, host_err, si_busy, init_done;
  logic [W-1:0] cfg_q;

  int n_run = 0, n_fail = 0;

  selfcfg_seq #(.CAL_CYCLES(NCAL), .CFG_W(W), .DEFAULT_CFG(DFLT)) dut (
    .clk(clk), .rst_n(rst_n), .lp_exit(lp_exit), .cal_req(cal_req), .cal_done(cal_done),
    .ee_rd(ee_rd), .ee_done(ee_done), .ee_valid(ee_valid), .ee_data(ee_data),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_err(host_err), .cfg_q(cfg_q),
    .si_busy(si_busy), .init_done(init_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: m_ph 0=calibrating, 1=reading EEPROM, 2=ready
  int m_ph, m_elapsed;
  logic m_seen, m_err;
  logic [W-1:0] m_cfg;

  function automatic logic [W-1:0] exp_ee_word(input logic v, input logic [W-1:0] d);
    if (v) return d;
    return DFLT;
  endfunction

  task automatic model_reset();
    m_ph = 0; m_elapsed = 0; m_seen = 0; m_err = 0; m_cfg = DFLT;
  endtask

  task automatic model_step();
    logic was_busy;
    was_busy = (m_ph != 2);
    m_err = host_wr && (was_busy || lp_exit);
    if (lp_exit) begin
      m_ph = 0; m_elapsed = 0; m_seen = 0;
    end else begin
      if (host_wr && !was_busy) m_cfg = host_wdata;
      case (m_ph)
        0: begin
          if (m_elapsed >= NCAL - 1 && (m_seen || cal_done)) begin
            m_ph = 1; m_seen = 0;
          end else begin
            m_seen = m_seen || cal_done;
            if (m_elapsed < NCAL - 1) m_elapsed++;
          end
        end
        1: if (ee_done) begin
          m_cfg = exp_ee_word(ee_valid, ee_data); m_ph = 2;
        end
        default: ;
      endcase
    end
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2", "cal_req", 32'(cal_req), 32'(m_ph == 0));
    check("R3", "ee_rd", 32'(ee_rd), 32'(m_ph == 1));
    check("R6", "si_busy", 32'(si_busy), 32'(m_ph != 2));
    check("R6", "init_done", 32'(init_done), 32'(m_ph == 2));
    check("R7", "host_err", 32'(host_err), 32'(m_err));
    check("R4", "cfg_q", 32'(cfg_q), 32'(m_cfg));
  endtask

  // One clock; inputs were set before the call, outputs sampled at the negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) model_reset(); else model_step();
    compare_all();
  endtask

  task automatic idle_inputs();
    lp_exit = 0; cal_done = 0; ee_done = 0; ee_valid = 0; host_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    #1;
    model_reset();
    check("R1", "busy in reset", 32'(si_busy), 32'd1);
    check("R1", "done in reset", 32'(init_done), 32'd0);
    check("R1", "cfg in reset", 32'(cfg_q), 32'(DFLT));
    tick();
    rst_n = 1;
    tick();
    check("R1", "busy after release", 32'(si_busy), 32'd1);
    check("R1", "ee_rd after release", 32'(ee_rd), 32'd0);
  endtask

  // Run to ready with cal_done held high; returns cycles until ee_rd rose
  task automatic run_to_ready(input logic valid, input logic [W-1:0] data, output int cal_cycles);
    cal_cycles = 0;
    cal_done = 1;
    while (!ee_rd && cal_cycles < 100) begin tick(); cal_cycles++; end
    cal_done = 0;
    ee_valid = valid; ee_data = data; ee_done = 1;
    tick();
    idle_inputs();
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd2024));
    model_reset();

    // Directed: reset and timer length
    do_reset();
    run_to_ready(1'b1, 16'hBEEF, cyc);
    check("R2", "cal cycles from release", 32'(cyc), 32'(NCAL - 1));
    check("R4", "valid load", 32'(cfg_q), 32'hBEEF);

    // Directed: invalid EEPROM falls back to default and still completes
    lp_exit = 1; tick(); lp_exit = 0;
    check("R9", "busy after lp_exit", 32'(si_busy), 32'd1);
    check("R9", "done after lp_exit", 32'(init_done), 32'd0);
    run_to_ready(1'b0, 16'h1234, cyc);
    check("R2", "cal cycles after restart", 32'(cyc), 32'(NCAL));
    check("R5", "default on invalid", 32'(cfg_q), 32'(DFLT));
    check("R5", "ready on invalid", 32'(init_done), 32'd1);

    // Directed: host write when ready, then refused while busy
    host_wr = 1; host_wdata = 16'h5A5A; tick(); host_wr = 0;
    check("R8", "host write ready", 32'(cfg_q), 32'h5A5A);
    check("R8", "no err ready", 32'(host_err), 32'd0);
    lp_exit = 1; tick(); lp_exit = 0;
    host_wr = 1; host_wdata = 16'hFFFF; tick(); host_wr = 0;
    check("R7", "err while busy", 32'(host_err), 32'd1);
    check("R7", "cfg kept while busy", 32'(cfg_q), 32'h5A5A);

    // Directed: late cal_done extends calibration; restart in EEPROM phase
    for (int i = 0; i < NCAL + 5; i++) tick();
    check("R2", "waits for cal_done", 32'(cal_req), 32'd1);
    cal_done = 1; tick(); cal_done = 0;
    check("R3", "ee_rd after late cal_done", 32'(ee_rd), 32'd1);
    lp_exit = 1; ee_done = 1; ee_valid = 1; ee_data = 16'h7777; tick(); idle_inputs();
    check("R9", "restart beats ee_done", 32'(cal_req), 32'd1);
    check("R9", "cfg untouched by aborted read", 32'(cfg_q), 32'h5A5A);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      lp_exit    = ($urandom_range(0, 99) < 2);
      cal_done   = ($urandom_range(0, 99) < 30);
      ee_done    = ($urandom_range(0, 99) < 25);
      ee_valid   = ($urandom_range(0, 1) == 1);
      ee_data    = W'($urandom);
      host_wr    = ($urandom_range(0, 99) < 30);
      host_wdata = W'($urandom);
      if ($urandom_range(0, 999) == 0) begin
        do_reset();
      end else begin
        tick();
      end
    end
    idle_inputs();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule